// File: doc/BRIEF.md
# Micro-step sequence patcher for branches and interrupt entry

This block sits between a micro-sequence store and the control lines of a microcoded processor. For every micro-step it receives the stored control word of the current opcode at the current step, together with the step number at which that stored sequence would clear the step counter. It returns the control word that should actually be applied. The processor's flag state, interrupt-inhibit bit and interrupt-request bit decide how that word is changed. Branch resolution happens by rewriting the sequence, so no separate branch unit is needed.

A conditional jump whose condition holds is replaced by a fixed jump sequence. An opcode that sets or clears the inhibit bit receives its toggle sequence when that change is meaningful. When an unmasked request is pending, a five-step interrupt-entry sequence is spliced in at the point where the instruction would otherwise end. The whole path is combinational. The surrounding step counter advances on the clock, and the patched word is valid in the same cycle as its inputs. Control words are logical: a set bit means the function is active, and polarity fixing happens downstream. The block has no streaming data path, so every pin is a plain level.

Top module: `ucode_patch`

## Requirements
- R1: With op_class = 1 (conditional jump), the jump is taken for jcond 0 when Z=1, 1 when Z=0, 2 when O=1, 3 when O=0, 4 when N=1, 5 when N=0, 6 when C=1, and 7 when C=0.
- R2: jcond 8 is taken only when both N and Z are 0. jcond 9 to 15 are never taken.
- R3: An untaken conditional jump leaves the sequence unchanged: with no injection, ctrl_word equals base_word at every step.
- R4: A taken jump outputs base_word at step 0. Steps 1 to 4 are replaced by: (PC_OUT bit 8 | RSEL=4 at bits 35:32 | XLO_WR bit 4 | PC_INC bit 7), then (PC_OUT | RSEL=4 | XHI_WR bit 5), then (XFER_OUT bit 9 | PC_LOAD bit 6), then STEP_RST bit 0. The end point of the sequence becomes step 4.
- R5: With irq_req=0, op_class 2 with irq_inhibit=0, or op_class 3 with irq_inhibit=1, outputs base_word at step 0, TOGGLE_II (bit 1) at step 1 and STEP_RST at step 2. The end point becomes 2. In any other flag state these classes keep base_word.
- R6: op_class 4 (reset) and 5 (handler) never receive interrupt entry and always output base_word.
- R7: When irq_req=1 and irq_inhibit=0, all other classes output five steps starting at the end point E: (ALU_ZERO bit 2 | ACC_WR bit 3 | WSEL=6 at bits 38:36), then (RSEL=15 | XHI_WR), then (RSEL=5 | XLO_WR), then (XFER_OUT | PC_LOAD), then STEP_RST. Steps before E are unchanged.
- R8: If an injection would need a step beyond 15 (E > 11), seq_err is 1 at every step and ctrl_word is all zeros. seq_err is 0 in every other case.
- R9: With irq_req=1 and irq_inhibit=1, no entry is injected and the inhibit classes are not rewritten. Only jump resolution applies.
- R10: After the end of a rewritten or injected sequence, every later step outputs all zeros. Unrewritten, uninjected sequences pass base_word at every step.
- R11: Class codes 6 and 7 behave as class 0 (plain instruction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 3 | Opcode class: 0 plain, 1 conditional jump, 2 set inhibit, 3 clear inhibit, 4 reset, 5 handler |
| jcond | input | 4 | Jump condition code for class 1 |
| flag_z | input | 1 | Zero flag |
| flag_o | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| irq_inhibit | input | 1 | Interrupt inhibit state |
| irq_req | input | 1 | Interrupt request pending |
| step | input | 4 | Current micro-step number |
| base_word | input | 48 | Stored control word of this opcode at this step |
| base_rst_step | input | 4 | Step at which the stored sequence clears the step counter |
| ctrl_word | output | 48 | Effective logical control word |
| seq_err | output | 1 | Injected sequence would overrun the step range |

## Verification
Every result is combinational, so ctrl_word and seq_err are due in the same cycle as the inputs that produce them. The bench changes the inputs just after a falling clock edge and samples 5 ns later, still well before the next rising edge. No register lies on the path, so no cycle offset needs to be counted. The sweep covers every class, condition code, flag combination and step for several end points, including 11 (the last end point that fits) and 12 (the first that overflows).

// File: rtl/ucp_pkg.sv
package ucp_pkg;

  parameter int CW_W   = 48;
  parameter int STEP_W = 4;

  typedef enum logic [2:0] {
    OPC_PLAIN   = 3'd0,
    OPC_BRANCH  = 3'd1,
    OPC_INH_SET = 3'd2,
    OPC_INH_CLR = 3'd3,
    OPC_BOOT    = 3'd4,
    OPC_ISR     = 3'd5
  } op_class_e;

  localparam logic [3:0] JC_ZS = 4'd0, JC_ZC = 4'd1, JC_OS = 4'd2, JC_OC = 4'd3,
                         JC_NS = 4'd4, JC_NC = 4'd5, JC_CS = 4'd6, JC_CC = 4'd7,
                         JC_GZ = 4'd8;

  // Control bit positions (logical, active-high)
  localparam int B_STEP_RST = 0;
  localparam int B_TOG_II   = 1;
  localparam int B_ALU_ZERO = 2;
  localparam int B_ACC_WR   = 3;
  localparam int B_XLO_WR   = 4;
  localparam int B_XHI_WR   = 5;
  localparam int B_PC_LOAD  = 6;
  localparam int B_PC_INC   = 7;
  localparam int B_PC_OUT   = 8;
  localparam int B_XFER_OUT = 9;
  localparam int RSEL_LSB   = 32;
  localparam int WSEL_LSB   = 36;

  localparam logic [3:0] RS_MEM = 4'd4, RS_IRQREG = 4'd5, RS_ACC = 4'd15;
  localparam logic [2:0] WS_IRQREG = 3'd6;

  localparam logic [CW_W-1:0] ONE = CW_W'(1);

  localparam int JMP_LEN = 4;
  localparam int INH_LEN = 2;
  localparam int IRQ_LEN = 5;

  function automatic logic [CW_W-1:0] jmp_word(input int unsigned idx);
    case (idx)
      1: return (ONE << B_PC_OUT) | (CW_W'(RS_MEM) << RSEL_LSB) |
                (ONE << B_XLO_WR) | (ONE << B_PC_INC);
      2: return (ONE << B_PC_OUT) | (CW_W'(RS_MEM) << RSEL_LSB) | (ONE << B_XHI_WR);
      3: return (ONE << B_XFER_OUT) | (ONE << B_PC_LOAD);
      4: return ONE << B_STEP_RST;
      default: return '0;
    endcase
  endfunction

  function automatic logic [CW_W-1:0] inh_word(input int unsigned idx);
    case (idx)
      1: return ONE << B_TOG_II;
      2: return ONE << B_STEP_RST;
      default: return '0;
    endcase
  endfunction

  function automatic logic [CW_W-1:0] irq_word(input int unsigned idx);
    case (idx)
      0: return (ONE << B_ALU_ZERO) | (ONE << B_ACC_WR) | (CW_W'(WS_IRQREG) << WSEL_LSB);
      1: return (CW_W'(RS_ACC) << RSEL_LSB) | (ONE << B_XHI_WR);
      2: return (CW_W'(RS_IRQREG) << RSEL_LSB) | (ONE << B_XLO_WR);
      3: return (ONE << B_XFER_OUT) | (ONE << B_PC_LOAD);
      4: return ONE << B_STEP_RST;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/ucp_cond_eval.sv
module ucp_cond_eval
  import ucp_pkg::*;
(
  input  logic [3:0] jcond,
  input  logic       flag_z,
  input  logic       flag_o,
  input  logic       flag_n,
  input  logic       flag_c,
  output logic       taken
);

  always_comb begin
    case (jcond)
      JC_ZS:   taken = flag_z;
      JC_ZC:   taken = !flag_z;
      JC_OS:   taken = flag_o;
      JC_OC:   taken = !flag_o;
      JC_NS:   taken = flag_n;
      JC_NC:   taken = !flag_n;
      JC_CS:   taken = flag_c;
      JC_CC:   taken = !flag_c;
      JC_GZ:   taken = !flag_n && !flag_z;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    if (jcond == JC_GZ && taken)
      a_r2_gz_needs_pos: assert (!flag_n && !flag_z)
        else $error("R2: greater-than-zero taken with N or Z set");
    if (jcond > JC_GZ)
      a_r2_spare_never: assert (!taken)
        else $error("R2: spare condition code taken");
  end

endmodule

// File: rtl/ucp_seq_rewrite.sv
module ucp_seq_rewrite
  import ucp_pkg::*;
#(
  parameter int W  = CW_W,
  parameter int SW = STEP_W
) (
  input  op_class_e       cls,
  input  logic            taken,
  input  logic            irq_inhibit,
  input  logic            irq_req,
  input  logic [SW-1:0]   step,
  input  logic [W-1:0]    base_word,
  input  logic [SW-1:0]   base_rst_step,
  output logic [W-1:0]    pat_word,
  output logic [SW-1:0]   pat_rst,
  output logic            patched
);

  localparam logic [SW-1:0] JMP_END = SW'(JMP_LEN);
  localparam logic [SW-1:0] INH_END = SW'(INH_LEN);

  logic jmp_on, inh_on;

  assign jmp_on = (cls == OPC_BRANCH) && taken;
  assign inh_on = !irq_req &&
                  (((cls == OPC_INH_SET) && !irq_inhibit) ||
                   ((cls == OPC_INH_CLR) &&  irq_inhibit));
  assign patched = jmp_on || inh_on;

  always_comb begin
    pat_word = base_word;
    pat_rst  = base_rst_step;
    if (jmp_on) begin
      pat_rst = JMP_END;
      if (step == '0)          pat_word = base_word;
      else if (step <= JMP_END) pat_word = W'(jmp_word(int'(step)));
      else                      pat_word = '0;
    end else if (inh_on) begin
      pat_rst = INH_END;
      if (step == '0)          pat_word = base_word;
      else if (step <= INH_END) pat_word = W'(inh_word(int'(step)));
      else                      pat_word = '0;
    end
  end

  always_comb begin
    if (irq_req && irq_inhibit && (cls == OPC_INH_SET || cls == OPC_INH_CLR))
      a_r9_no_inh_rewrite: assert (!patched)
        else $error("R9: inhibit rewrite while request masked");
  end

endmodule

// File: rtl/ucp_irq_inject.sv
module ucp_irq_inject
  import ucp_pkg::*;
#(
  parameter int W  = CW_W,
  parameter int SW = STEP_W
) (
  input  op_class_e       cls,
  input  logic            irq_inhibit,
  input  logic            irq_req,
  input  logic [SW-1:0]   step,
  input  logic [W-1:0]    pat_word,
  input  logic [SW-1:0]   pat_rst,
  input  logic            patched,
  output logic [W-1:0]    ctrl_word,
  output logic            seq_err
);

  localparam int            NSTEPS  = 1 << SW;
  localparam logic [SW-1:0] LAST_OK = SW'(NSTEPS - IRQ_LEN);
  localparam logic [SW-1:0] ILEN    = SW'(IRQ_LEN);

  logic          inject;
  logic [SW-1:0] offs;

  assign inject  = irq_req && !irq_inhibit && (cls != OPC_BOOT) && (cls != OPC_ISR);
  assign seq_err = inject && (pat_rst > LAST_OK);
  assign offs    = step - pat_rst;

  always_comb begin
    if (!inject)               ctrl_word = pat_word;
    else if (seq_err)          ctrl_word = '0;
    else if (step < pat_rst)   ctrl_word = pat_word;
    else if (offs < ILEN)      ctrl_word = W'(irq_word(int'(offs)));
    else                       ctrl_word = '0;
  end

  always_comb begin
    if (inject && !seq_err && step == pat_rst)
      a_r7_entry_first: assert (ctrl_word[B_ALU_ZERO] && !ctrl_word[B_STEP_RST])
        else $error("R7: entry step missing at end point");
    if (!inject && !patched)
      a_r10_plain_pass: assert (ctrl_word == pat_word)
        else $error("R10: unpatched word altered");
  end

endmodule

// File: rtl/ucode_patch.sv
module ucode_patch
  import ucp_pkg::*;
(
  input  logic [2:0]       op_class,
  input  logic [3:0]       jcond,
  input  logic             flag_z,
  input  logic             flag_o,
  input  logic             flag_n,
  input  logic             flag_c,
  input  logic             irq_inhibit,
  input  logic             irq_req,
  input  logic [3:0]       step,
  input  logic [47:0]      base_word,
  input  logic [3:0]       base_rst_step,
  output logic [47:0]      ctrl_word,
  output logic             seq_err
);

  op_class_e             cls;
  logic                  taken;
  logic [CW_W-1:0]       pat_word;
  logic [STEP_W-1:0]     pat_rst;
  logic                  patched;

  always_comb begin
    case (op_class)
      3'd1:    cls = OPC_BRANCH;
      3'd2:    cls = OPC_INH_SET;
      3'd3:    cls = OPC_INH_CLR;
      3'd4:    cls = OPC_BOOT;
      3'd5:    cls = OPC_ISR;
      default: cls = OPC_PLAIN;
    endcase
  end

  ucp_cond_eval u_cond (
    .jcond  (jcond),
    .flag_z (flag_z),
    .flag_o (flag_o),
    .flag_n (flag_n),
    .flag_c (flag_c),
    .taken  (taken)
  );

  ucp_seq_rewrite #(.W(CW_W), .SW(STEP_W)) u_rew (
    .cls           (cls),
    .taken         (taken && (cls == OPC_BRANCH)),
    .irq_inhibit   (irq_inhibit),
    .irq_req       (irq_req),
    .step          (step),
    .base_word     (base_word),
    .base_rst_step (base_rst_step),
    .pat_word      (pat_word),
    .pat_rst       (pat_rst),
    .patched       (patched)
  );

  ucp_irq_inject #(.W(CW_W), .SW(STEP_W)) u_inj (
    .cls         (cls),
    .irq_inhibit (irq_inhibit),
    .irq_req     (irq_req),
    .step        (step),
    .pat_word    (pat_word),
    .pat_rst     (pat_rst),
    .patched     (patched),
    .ctrl_word   (ctrl_word),
    .seq_err     (seq_err)
  );

  always_comb begin
    if (seq_err)
      a_r8_err_needs_irq: assert (irq_req && !irq_inhibit)
        else $error("R8: overrun flagged without pending request");
    if (seq_err)
      a_r8_err_quiet: assert (ctrl_word == '0)
        else $error("R8: word not quiet on overrun");
    if (op_class == 3'd5 || op_class == 3'd4)
      a_r6_fixed_untouched: assert (ctrl_word == base_word && !seq_err)
        else $error("R6: reset or handler sequence altered");
    if (op_class == 3'd1 && !taken && !(irq_req && !irq_inhibit))
      a_r3_untaken_passthru: assert (ctrl_word == base_word)
        else $error("R3: untaken jump altered");
  end

endmodule

// File: tb/sim_ucode_patch.sv
module sim_ucode_patch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_class = '0;
  logic [3:0]  jcond = '0;
  logic        flag_z = 1'b0, flag_o = 1'b0, flag_n = 1'b0, flag_c = 1'b0;
  logic        irq_inhibit = 1'b0, irq_req = 1'b0;
  logic [3:0]  step = '0;
  logic [47:0] base_word = '0;
  logic [3:0]  base_rst_step = '0;
  logic [47:0] ctrl_word;
  logic        seq_err;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ucode_patch u0 (
    .op_class (op_class), .jcond (jcond),
    .flag_z (flag_z), .flag_o (flag_o), .flag_n (flag_n), .flag_c (flag_c),
    .irq_inhibit (irq_inhibit), .irq_req (irq_req),
    .step (step), .base_word (base_word), .base_rst_step (base_rst_step),
    .ctrl_word (ctrl_word), .seq_err (seq_err)
  );

  // Reference words built from the bit positions stated in the requirements
  function automatic logic [47:0] bt(input int p);
    return 48'd1 << p;
  endfunction

  function automatic logic [47:0] ref_jmp(input int i);
    case (i)
      1: return bt(8) | (48'd4 << 32) | bt(4) | bt(7);
      2: return bt(8) | (48'd4 << 32) | bt(5);
      3: return bt(9) | bt(6);
      4: return bt(0);
      default: return 48'd0;
    endcase
  endfunction

  function automatic logic [47:0] ref_irq(input int i);
    case (i)
      0: return bt(2) | bt(3) | (48'd6 << 36);
      1: return (48'd15 << 32) | bt(5);
      2: return (48'd5 << 32) | bt(4);
      3: return bt(9) | bt(6);
      4: return bt(0);
      default: return 48'd0;
    endcase
  endfunction

  function automatic bit ref_taken(input int jc, input bit z, input bit o, input bit n, input bit c);
    case (jc)
      0: return z;   1: return !z;
      2: return o;   3: return !o;
      4: return n;   5: return !n;
      6: return c;   7: return !c;
      8: return !n && !z;
      default: return 1'b0;
    endcase
  endfunction

  logic [47:0] exp_word;
  bit          exp_err;
  string       exp_tag;

  task automatic compute_expected();
    int cls, e, s;
    bit tk, inh, inj, rew;
    logic [47:0] pw;
    cls = (op_class > 3'd5) ? 0 : int'(op_class);
    s = int'(step);
    tk  = (cls == 1) && ref_taken(int'(jcond), flag_z, flag_o, flag_n, flag_c);
    inh = !irq_req && ((cls == 2 && !irq_inhibit) || (cls == 3 && irq_inhibit));
    rew = tk || inh;
    pw = base_word;
    e = int'(base_rst_step);
    exp_tag = (cls == 1) ? (tk ? "R4" : "R3") : (cls >= 4 ? "R6" : "R11");
    if (cls == 2 || cls == 3) exp_tag = "R5";
    if (tk) begin
      e = 4;
      pw = (s == 0) ? base_word : ref_jmp(s);
    end else if (inh) begin
      e = 2;
      pw = (s == 0) ? base_word : (s == 1 ? bt(1) : (s == 2 ? bt(0) : 48'd0));
    end
    if (rew && s > e) exp_tag = "R10";
    if (irq_req && irq_inhibit) exp_tag = (cls == 1) ? exp_tag : "R9";
    inj = irq_req && !irq_inhibit && cls != 4 && cls != 5;
    exp_err = inj && (e > 11);
    if (!inj) exp_word = pw;
    else if (exp_err) begin exp_word = 48'd0; exp_tag = "R8"; end
    else if (s < e) exp_word = pw;
    else if (s - e < 5) begin exp_word = ref_irq(s - e); exp_tag = "R7"; end
    else begin exp_word = 48'd0; exp_tag = "R10"; end
    if (cls == 1 && (jcond == 4'd8) && tk) exp_tag = "R2";
    if (cls == 1 && s == 1 && !inj) exp_tag = tk ? "R1" : exp_tag;
  endtask

  // Drive just after a falling edge; the path is combinational, sample 5 ns later
  task automatic apply_check();
    @(negedge clk);
    #5;
    compute_expected();
    vectors++;
    if (ctrl_word !== exp_word || seq_err !== exp_err) begin
      fails++;
      $display("FAIL %s: cls=%0d jc=%0d zonc=%b%b%b%b ii=%b irq=%b step=%0d end=%0d got word=%h err=%b exp word=%h err=%b",
               exp_tag, op_class, jcond, flag_z, flag_o, flag_n, flag_c, irq_inhibit, irq_req,
               step, base_rst_step, ctrl_word, seq_err, exp_word, exp_err);
    end
  endtask

  task automatic set_flags(input int f);
    flag_c = f[0]; flag_n = f[1]; flag_o = f[2]; flag_z = f[3];
    irq_req = f[4]; irq_inhibit = f[5];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle inputs: plain class, zero word passes straight through (R10)
    apply_check();
    // R1 R2 R3 R4 R7 R8: jump classes over every condition, flag state and step
    op_class = 3'd1;
    for (int jc = 0; jc < 16; jc++)
      for (int ei = 0; ei < 3; ei++)
        for (int f = 0; f < 64; f++)
          for (int s = 0; s < 16; s++) begin
            jcond = 4'(jc);
            base_rst_step = (ei == 0) ? 4'd2 : (ei == 1 ? 4'd11 : 4'd12);
            set_flags(f);
            step = 4'(s);
            base_word = 48'hC3A5_0F1E_7700 ^ (48'(s) << 40) ^ 48'(jc);
            apply_check();
          end
    // R5 R6 R9 R10 R11 and injection for other classes
    for (int c = 0; c < 8; c++) begin
      if (c == 1) continue;
      for (int ei = 0; ei < 4; ei++)
        for (int f = 0; f < 64; f++)
          for (int s = 0; s < 16; s++) begin
            op_class = 3'(c);
            jcond = 4'(f);
            base_rst_step = (ei == 0) ? 4'd0 : (ei == 1 ? 4'd5 : (ei == 2 ? 4'd11 : 4'd12));
            set_flags(f);
            step = 4'(s);
            base_word = 48'h5A5A_1234_00FF ^ (48'(s) << 20) ^ (48'(c) << 44);
            apply_check();
          end
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got cycles=%0d expected completion", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule